// File: doc/BRIEF.md
# Dwell-Qualified Two-State Toggler

This block holds one of two states, called A and B, and changes between them only when the input `xIn` has stayed high long enough. A counter counts clock edges at which `xIn` is sampled high. It is cleared whenever `xIn` is sampled low, so only an unbroken run of high samples counts. Leaving A needs a run of `UP_DWELL` high samples, with a default of three. Leaving B needs a run of `DOWN_DWELL` high samples, with a default of five.

At the edge that completes the run, the state flips and the counter clears. The next stay therefore needs a fresh run of its own. The output `stateB` shows the current state. A one-cycle `switchPulse` marks the first cycle of each new state, so the timing of every transition can be seen at the ports. Reset is synchronous and puts the block in state A.

Top module: `dwell_toggler`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the outputs after that edge are `stateB`=0 (state A) and `switchPulse`=0, and the run count is cleared.
- R2: In state A, `stateB` becomes 1 after the edge that samples the `UP_DWELL`-th (default 3rd) consecutive high value of `xIn`, and not after any earlier edge.
- R3: At an edge where `xIn` is sampled low, the state does not change and `switchPulse` is 0 after that edge.
- R4: A low sample of `xIn` before the run completes clears the count, so a later transition needs a complete new run of high samples (for example, high-high-low-high-high-high in state A switches only after the last sample).
- R5: In state B, `stateB` returns to 0 after the edge that samples the `DOWN_DWELL`-th (default 5th) consecutive high value of `xIn`.
- R6: `switchPulse` is 1 for exactly the one cycle after each edge at which the state changes, and 0 in every other cycle.
- R7: The count restarts from zero at every transition. With `xIn` held high all the time, the block alternates: `UP_DWELL` edges in A, then `DOWN_DWELL` edges in B, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xIn | input | 1 | Qualifying level, sampled on each rising edge |
| stateB | output | 1 | 1 in state B, 0 in state A |
| switchPulse | output | 1 | One-cycle pulse in the first cycle of a new state |

## Verification
The bound checker keeps its own run-length count taken from the ports. On every cycle it checks that a pulse and a state flip follow exactly the edge that completes a run, and never an earlier one. It also checks that a low sample leaves the state unchanged, that the pulse coincides with each state change, and that reset lands in state A. The bench scenarios cover what needs a specific history. These are a run broken one sample short of its target in each state, low stretches of varying length, continuous high input that cycles the block through both dwell lengths several times, and a reset applied in the middle of state B.

// File: rtl/dwell_pkg.sv
package dwell_pkg;

  typedef enum logic {
    ST_A = 1'b0,
    ST_B = 1'b1
  } dwell_state_t;

  // Strobes from control to the run counter
  typedef struct packed {
    logic clr;  // return the count to zero
    logic inc;  // advance the count by one
  } cnt_op_t;

endpackage

// File: rtl/dwell_datapath.sv
module dwell_datapath #(
  parameter int UP_DWELL   = 3,
  parameter int DOWN_DWELL = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  dwell_pkg::cnt_op_t cntOp,
  input  logic              useDown,
  output logic              lastStep
);
  localparam int MAX_DWELL = (UP_DWELL > DOWN_DWELL) ? UP_DWELL : DOWN_DWELL;
  localparam int CW        = (MAX_DWELL > 1) ? $clog2(MAX_DWELL) : 1;
  localparam logic [CW-1:0] UP_LAST   = CW'(UP_DWELL - 1);
  localparam logic [CW-1:0] DOWN_LAST = CW'(DOWN_DWELL - 1);

  logic [CW-1:0] runCnt;
  logic [CW-1:0] lastValue;

  // Count value reached just before the sample that completes the run
  assign lastValue = useDown ? DOWN_LAST : UP_LAST;
  assign lastStep  = (runCnt == lastValue);

  always_ff @(posedge clk) begin
    if (rst || cntOp.clr) begin
      runCnt <= '0;
    end else if (cntOp.inc) begin
      runCnt <= runCnt + CW'(1);
    end
  end

endmodule

// File: rtl/dwell_control.sv
module dwell_control (
  input  logic               clk,
  input  logic               rst,
  input  logic               xIn,
  input  logic               lastStep,
  output dwell_pkg::cnt_op_t cntOp,
  output logic               useDown,
  output logic               stateB,
  output logic               switchPulse
);
  import dwell_pkg::*;

  dwell_state_t curState;
  logic         doToggle;

  assign doToggle  = xIn && lastStep;
  assign useDown   = (curState == ST_B);
  assign cntOp.clr = !xIn || lastStep;
  assign cntOp.inc = xIn && !lastStep;

  always_ff @(posedge clk) begin
    if (rst) begin
      curState    <= ST_A;
      switchPulse <= 1'b0;
    end else begin
      if (doToggle) begin
        curState <= (curState == ST_A) ? ST_B : ST_A;
      end
      switchPulse <= doToggle;
    end
  end

  assign stateB = (curState == ST_B);

endmodule

// File: rtl/dwell_toggler.sv
module dwell_toggler #(
  parameter int UP_DWELL   = 3,
  parameter int DOWN_DWELL = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic xIn,
  output logic stateB,
  output logic switchPulse
);
  dwell_pkg::cnt_op_t cntOp;
  logic               useDown;
  logic               lastStep;

  dwell_control u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .xIn         (xIn),
    .lastStep    (lastStep),
    .cntOp       (cntOp),
    .useDown     (useDown),
    .stateB      (stateB),
    .switchPulse (switchPulse)
  );

  dwell_datapath #(
    .UP_DWELL   (UP_DWELL),
    .DOWN_DWELL (DOWN_DWELL)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .cntOp    (cntOp),
    .useDown  (useDown),
    .lastStep (lastStep)
  );

endmodule

// File: rtl/dwell_toggler_chk.sv
module dwell_toggler_chk #(
  parameter int UP_DWELL   = 3,
  parameter int DOWN_DWELL = 5
) (
  input logic clk,
  input logic rst,
  input logic xIn,
  input logic stateB,
  input logic switchPulse
);
  // Run length observed at the ports, kept independently of the datapath
  int  chkRun;
  int  chkTarget;
  logic runDone;

  assign chkTarget = stateB ? DOWN_DWELL : UP_DWELL;
  assign runDone   = xIn && ((chkRun + 1) == chkTarget);

  always_ff @(posedge clk) begin
    if (rst || !xIn || runDone) begin
      chkRun <= 0;
    end else begin
      chkRun <= chkRun + 1;
    end
  end

  a_r1_reset_to_a: assert property (@(posedge clk)
    rst |=> (!stateB && !switchPulse));

  a_r3_low_holds: assert property (@(posedge clk) disable iff (rst)
    !xIn |=> ($stable(stateB) && !switchPulse));

  // R2 and R5: completing a run flips the state
  a_r2_r5_run_done_switches: assert property (@(posedge clk) disable iff (rst)
    runDone |=> (switchPulse && (stateB != $past(stateB))));

  a_r4_no_early_switch: assert property (@(posedge clk) disable iff (rst)
    !runDone |=> (!switchPulse && $stable(stateB)));

  a_r6_pulse_with_change: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (switchPulse == (stateB != $past(stateB))));

endmodule

bind dwell_toggler dwell_toggler_chk #(
  .UP_DWELL   (UP_DWELL),
  .DOWN_DWELL (DOWN_DWELL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .xIn         (xIn),
  .stateB      (stateB),
  .switchPulse (switchPulse)
);

// File: tb/tb_dwell_toggler.sv
module tb_dwell_toggler;
  localparam int UP_N = 3;
  localparam int DN_N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xIn = 1'b0;
  logic stateB;
  logic switchPulse;

  int applied = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Expected {stateB, switchPulse} after each edge, with a requirement tag
  logic [1:0] expQ[$];
  string      tagQ[$];

  // Model built from the requirements
  bit mState = 1'b0;
  int mRun = 0;

  always #4 clk = ~clk;  // 125 MHz

  dwell_toggler #(.UP_DWELL(UP_N), .DOWN_DWELL(DN_N)) dut (
    .clk(clk), .rst(rst), .xIn(xIn), .stateB(stateB), .switchPulse(switchPulse)
  );

  // Driver: called at a falling edge, sets inputs for the next rising edge
  task automatic step(input bit r, input bit x, input string tag);
    bit sw;
    rst = r;
    xIn = x;
    sw = 1'b0;
    if (r) begin
      mState = 1'b0;
      mRun = 0;
    end else if (!x) begin
      mRun = 0;
    end else begin
      mRun++;
      if (mRun == (mState ? DN_N : UP_N)) begin
        mState = ~mState;
        mRun = 0;
        sw = 1'b1;
      end
    end
    expQ.push_back({mState, sw});
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input bit x, input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, x, tag);
  endtask

  // Monitor: compares each output one time unit after the rising edge
  always @(posedge clk) begin
    if (expQ.size() != 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      #1;
      applied++;
      if ({stateB, switchPulse} !== e) begin
        failures++;
        $display("FAIL %s: {stateB,switchPulse} actual=%b expected=%b at %0t",
                 t, {stateB, switchPulse}, e, $time);
      end
    end
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    run(1'b0, 4, "R3");
    // R4: run broken one short in A
    run(1'b1, 2, "R4");
    run(1'b0, 1, "R4");
    // R2: full run of UP_N in A, pulse on entry (R6)
    run(1'b1, 2, "R2");
    run(1'b1, 1, "R6");
    run(1'b0, 3, "R3");
    // R4: run broken one short in B
    run(1'b1, DN_N - 1, "R4");
    run(1'b0, 2, "R4");
    // R5: full run in B
    run(1'b1, DN_N, "R5");
    run(1'b0, 1, "R6");
    // R7: continuous high alternates through both dwell lengths
    run(1'b1, 3 * (UP_N + DN_N), "R7");
    // R1: reset in the middle of B
    run(1'b0, 1, "R3");
    run(1'b1, UP_N + 2, "R7");
    step(1'b1, 1'b1, "R1");
    run(1'b1, UP_N, "R2");
    run(1'b0, 2, "R3");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failures);
      $finish;
    end
  end

endmodule